// File: doc/BRIEF.md
# I2C Slave Register Access Port

This block is an I2C target with a fixed 7-bit device address. Through it a bus master reaches a small bank of byte-wide registers, addressed by an internal pointer that advances on its own. The block samples SCL and SDA with the system clock and recognises START, repeated START and STOP. It pulls SDA low by asserting an output-enable; the pad and the pull-up sit outside the block. Clock stretching, general call and speeds above 400 kHz are not supported.

In a write transfer, the first byte after the address is the pointer. Each later byte is stored at the pointer, and the pointer then moves on by one. A read transfer returns bytes starting at the pointer. It may follow a pointer-setting write through a repeated START, or it may stand alone and continue from whatever pointer value is left. Pointer values outside the bank are refused. Bits that a register does not implement always read as zero. The whole bank is presented in parallel to the logic around the block.

Top module: `i2c_regport`

## Requirements
- R1: The block acknowledges only the address byte 0xD0 (write) or 0xD1 (read), i.e. device address 7'h68 with the R/W bit in bit 0. Any other address byte gets no acknowledge, and the block stays passive until the next START.
- R2: START (SDA falls while SCL is high) restarts byte reception from any state. A START that arrives without an earlier STOP acts as a repeated START. STOP (SDA rises while SCL is high) returns the block to idle with SDA released.
- R3: In a write, the byte after the address loads the pointer. Each following byte is stored at the pointer and acknowledged, and the pointer then increments.
- R4: In a read, bytes are sent MSB first from the pointer location. The pointer increments after each byte, and the next byte follows as long as the master acknowledges.
- R5: A read that is not preceded by a pointer write starts at the pointer value left by the previous transfer.
- R6: When the master does not acknowledge a read byte, the block releases SDA and drives nothing until the next START.
- R7: A pointer byte of 0x10 or above is not acknowledged. The pointer keeps its value, and the bytes after it in that transfer are neither acknowledged nor stored.
- R8: Unimplemented bits read as zero whatever was written. The implemented-bit masks per index are: 0–2: 0x7F, 3: 0x07, 4: 0x3F, 5: 0x9F, 6–13: 0xFF, 14: 0x9F, 15: 0x83.
- R9: The pointer wraps from index 15 to index 0, both when writing and when reading.
- R10: After reset, SDA is released and every register reads zero.
- R11: The block changes its SDA drive only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 20 MHz |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock as seen at the pad |
| sda_i | input | 1 | Bus data as seen at the pad (wired-AND of all drivers) |
| sda_oe | output | 1 | High pulls SDA low |
| regs_o | output | 128 | Register bank, index i in bits [8i+7:8i] |

## Verification
The assertions assume that the bus is well formed. SCL and SDA change far more slowly than the system clock, and SDA moves only while SCL is low, except where it marks START or STOP. They also assume that no other agent holds SDA low while this block is transmitting. The bench master keeps each bus quarter-period at eight system clocks. It changes SDA only in the middle of the SCL-low phase. On the data line it models an open-drain wired-AND between its own drive and the block's enable. This keeps every transfer inside these assumptions, including the misaddressed and refused-pointer transfers.

// File: rtl/i2c_regport_pkg.sv
package i2c_regport_pkg;

  typedef enum logic [2:0] {
    PH_IDLE, PH_RX, PH_ACK, PH_TX, PH_MACK
  } phase_t;

  typedef enum logic [1:0] {
    RL_ADDR, RL_PTR, RL_DATA
  } role_t;

  // Implemented bits of each register index.
  function automatic logic [7:0] reg_wmask(input int idx);
    logic [7:0] m;
    if (idx <= 2)       m = 8'h7F;
    else if (idx == 3)  m = 8'h07;
    else if (idx == 4)  m = 8'h3F;
    else if (idx == 5)  m = 8'h9F;
    else if (idx <= 13) m = 8'hFF;
    else if (idx == 14) m = 8'h9F;
    else if (idx == 15) m = 8'h83;
    else                m = 8'hFF;
    return m;
  endfunction

  function automatic logic addr_hit(input logic [7:0] b, input logic [6:0] dev);
    return b[7:1] == dev;
  endfunction

  function automatic logic ptr_ok(input logic [7:0] b, input int nreg);
    return int'(b) < nreg;
  endfunction

endpackage

// File: rtl/i2c_regport_sync.sv
module i2c_regport_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_evt,
  output logic stop_evt
);
  logic [STAGES-1:0] scl_q, sda_q;
  logic scl_d, sda_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= '1;
      sda_q <= '1;
      scl_d <= 1'b1;
      sda_d <= 1'b1;
    end else begin
      scl_q <= {scl_q[STAGES-2:0], scl_i};
      sda_q <= {sda_q[STAGES-2:0], sda_i};
      scl_d <= scl_q[STAGES-1];
      sda_d <= sda_q[STAGES-1];
    end
  end

  assign scl_s     = scl_q[STAGES-1];
  assign sda_s     = sda_q[STAGES-1];
  assign scl_rise  = scl_s & ~scl_d;
  assign scl_fall  = ~scl_s & scl_d;
  assign start_evt = scl_s & scl_d & sda_d & ~sda_s;
  assign stop_evt  = scl_s & scl_d & ~sda_d & sda_s;
endmodule

// File: rtl/i2c_regport_fsm.sv
module i2c_regport_fsm
  import i2c_regport_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h68,
  parameter int NREG = 16,
  localparam int AW = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sda_s,
  input  logic          scl_rise,
  input  logic          scl_fall,
  input  logic          start_evt,
  input  logic          stop_evt,
  input  logic [7:0]    rd_data,
  output logic [AW-1:0] rd_addr,
  output logic          wr_en,
  output logic [AW-1:0] wr_addr,
  output logic [7:0]    wr_data,
  output logic          sda_oe,
  output logic          fsm_idle,
  output logic          ptr_rej
);
  phase_t        phase;
  role_t         role;
  logic [7:0]    sh;
  logic [3:0]    bcnt;
  logic          rw;
  logic          mack;
  logic [AW-1:0] ptr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= PH_IDLE; role <= RL_ADDR; sh <= '0; bcnt <= '0;
      rw <= 1'b0; mack <= 1'b0; ptr <= '0; sda_oe <= 1'b0;
      wr_en <= 1'b0; wr_addr <= '0; wr_data <= '0; ptr_rej <= 1'b0;
    end else begin
      wr_en   <= 1'b0;
      ptr_rej <= 1'b0;
      if (start_evt) begin
        phase <= PH_RX; role <= RL_ADDR; bcnt <= '0; sda_oe <= 1'b0;
      end else if (stop_evt) begin
        phase <= PH_IDLE; sda_oe <= 1'b0;
      end else begin
        unique case (phase)
          PH_RX: begin
            if (scl_rise) begin
              sh   <= {sh[6:0], sda_s};
              bcnt <= bcnt + 4'd1;
            end else if (scl_fall && bcnt == 4'd8) begin
              bcnt <= '0;
              unique case (role)
                RL_ADDR: begin
                  if (addr_hit(sh, DEV_ADDR)) begin
                    rw <= sh[0]; sda_oe <= 1'b1; phase <= PH_ACK;
                  end else begin
                    phase <= PH_IDLE;
                  end
                end
                RL_PTR: begin
                  if (ptr_ok(sh, NREG)) begin
                    ptr <= sh[AW-1:0]; sda_oe <= 1'b1; phase <= PH_ACK;
                  end else begin
                    ptr_rej <= 1'b1; phase <= PH_IDLE;
                  end
                end
                default: begin
                  wr_en <= 1'b1; wr_addr <= ptr; wr_data <= sh;
                  ptr <= ptr + 1'b1; sda_oe <= 1'b1; phase <= PH_ACK;
                end
              endcase
            end
          end
          PH_ACK: begin
            if (scl_fall) begin
              if (role == RL_ADDR && rw) begin
                phase <= PH_TX; role <= RL_DATA; sh <= rd_data;
                sda_oe <= ~rd_data[7]; bcnt <= '0;
              end else begin
                sda_oe <= 1'b0; phase <= PH_RX;
                role <= (role == RL_ADDR) ? RL_PTR : RL_DATA;
              end
            end
          end
          PH_TX: begin
            if (scl_fall) begin
              if (bcnt == 4'd7) begin
                sda_oe <= 1'b0; phase <= PH_MACK; ptr <= ptr + 1'b1;
              end else begin
                sh <= {sh[6:0], 1'b0}; sda_oe <= ~sh[6]; bcnt <= bcnt + 4'd1;
              end
            end
          end
          PH_MACK: begin
            if (scl_rise) begin
              mack <= ~sda_s;
            end else if (scl_fall) begin
              if (mack) begin
                phase <= PH_TX; sh <= rd_data; sda_oe <= ~rd_data[7]; bcnt <= '0;
              end else begin
                phase <= PH_IDLE; sda_oe <= 1'b0;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign rd_addr  = ptr;
  assign fsm_idle = (phase == PH_IDLE);
endmodule

// File: rtl/i2c_regport_bank.sv
module i2c_regport_bank
  import i2c_regport_pkg::*;
#(
  parameter int NREG = 16,
  localparam int AW = $clog2(NREG)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [AW-1:0]   wr_addr,
  input  logic [7:0]      wr_data,
  input  logic [AW-1:0]   rd_addr,
  output logic [7:0]      rd_data,
  output logic [NREG*8-1:0] regs_o
);
  logic [7:0] mem [NREG];

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        mem[i] <= '0;
      else if (wr_en && wr_addr == AW'(i))
        mem[i] <= wr_data & reg_wmask(i);
    end
    assign regs_o[i*8 +: 8] = mem[i];
  end

  assign rd_data = mem[rd_addr];
endmodule

// File: rtl/i2c_regport.sv
module i2c_regport #(
  parameter logic [6:0] DEV_ADDR = 7'h68,
  parameter int NREG = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe,
  output logic [NREG*8-1:0] regs_o
);
  localparam int AW = $clog2(NREG);

  logic scl_s, sda_s, scl_rise, scl_fall, start_evt, stop_evt;
  logic wr_en, fsm_idle, ptr_rej;
  logic [AW-1:0] wr_addr, rd_addr;
  logic [7:0] wr_data, rd_data;

  i2c_regport_sync #(.STAGES(2)) u_sync (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_evt(start_evt), .stop_evt(stop_evt)
  );

  i2c_regport_fsm #(.DEV_ADDR(DEV_ADDR), .NREG(NREG)) u_fsm (
    .clk(clk), .rst_n(rst_n), .sda_s(sda_s), .scl_rise(scl_rise),
    .scl_fall(scl_fall), .start_evt(start_evt), .stop_evt(stop_evt),
    .rd_data(rd_data), .rd_addr(rd_addr), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .sda_oe(sda_oe), .fsm_idle(fsm_idle), .ptr_rej(ptr_rej)
  );

  i2c_regport_bank #(.NREG(NREG)) u_bank (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .regs_o(regs_o)
  );
endmodule

// File: rtl/i2c_regport_chk.sv
module i2c_regport_chk
  import i2c_regport_pkg::*;
#(
  parameter int NREG = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              scl_s,
  input logic              sda_oe,
  input logic              start_evt,
  input logic              stop_evt,
  input logic              fsm_idle,
  input logic              wr_en,
  input logic              ptr_rej,
  input logic [NREG*8-1:0] regs_o
);
  function automatic logic [NREG*8-1:0] spare_bits();
    logic [NREG*8-1:0] v;
    for (int i = 0; i < NREG; i++) v[i*8 +: 8] = ~reg_wmask(i);
    return v;
  endfunction
  localparam logic [NREG*8-1:0] SPARE = spare_bits();

  p_drive_scl_low_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_s && $past(scl_s)) |-> $stable(sda_oe));

  p_spare_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (regs_o & SPARE) == '0);

  p_start_active_r2: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt |=> !fsm_idle);

  p_stop_release_r2: assert property (@(posedge clk) disable iff (!rst_n)
    stop_evt |=> (fsm_idle && !sda_oe));

  p_store_acks_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> sda_oe);

  p_bad_ptr_nack_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ptr_rej |-> (fsm_idle && !sda_oe));

  p_idle_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    fsm_idle |-> !sda_oe);
endmodule

bind i2c_regport i2c_regport_chk #(.NREG(NREG)) u_chk (
  .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_oe(sda_oe),
  .start_evt(start_evt), .stop_evt(stop_evt), .fsm_idle(fsm_idle),
  .wr_en(wr_en), .ptr_rej(ptr_rej), .regs_o(regs_o)
);

// File: tb/i2c_regport_bench.sv
module i2c_regport_bench;
  localparam int NR = 16;
  localparam int Q  = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1;
  logic sda_m = 1'b1;
  logic sda_oe;
  logic [NR*8-1:0] regs_o;
  wire  sda_line = sda_m & ~sda_oe;

  always #2 clk = ~clk;

  i2c_regport u_i2c_regport (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
    .sda_oe(sda_oe), .regs_o(regs_o)
  );

  int tests = 0, fails = 0;
  int model [NR];
  int mptr = 0;
  bit cmp_en = 1'b0;
  bit mis_told = 1'b0;
  bit done = 1'b0;

  function automatic int keep_bits(int idx);
    case (idx)
      0, 1, 2: return 'h7F;
      3:       return 'h07;
      4:       return 'h3F;
      5, 14:   return 'h9F;
      15:      return 'h83;
      default: return 'hFF;
    endcase
  endfunction

  task automatic chk(string req, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // Reference bank compared on every clock (R3, R8, R9 storage)
  always @(negedge clk) begin
    if (cmp_en && rst_n) begin
      for (int i = 0; i < NR; i++) begin
        if (int'(regs_o[i*8 +: 8]) != model[i]) begin
          fails++;
          if (!mis_told)
            $display("FAIL R3: reg %0d actual 0x%0h expected 0x%0h",
                     i, regs_o[i*8 +: 8], model[i]);
          mis_told = 1'b1;
        end
      end
    end
  end

  task automatic wt(int n); repeat (n) @(negedge clk); endtask
  task automatic bus_start(); sda_m = 1; wt(Q); scl_m = 1; wt(Q); sda_m = 0; wt(Q); scl_m = 0; wt(Q); endtask
  task automatic bus_stop(); sda_m = 0; wt(Q); scl_m = 1; wt(Q); sda_m = 1; wt(2*Q); endtask
  task automatic put_bit(bit b); sda_m = b; wt(Q); scl_m = 1; wt(2*Q); scl_m = 0; wt(Q); endtask

  task automatic put_byte(logic [7:0] b, output bit acked);
    for (int i = 7; i >= 0; i--) put_bit(b[i]);
    sda_m = 1; wt(Q); scl_m = 1; wt(Q); acked = !sda_line; wt(Q); scl_m = 0; wt(Q);
  endtask

  task automatic get_byte(bit ack, output logic [7:0] b);
    sda_m = 1; b = '0;
    for (int i = 0; i < 8; i++) begin
      wt(Q); scl_m = 1; wt(Q); b = {b[6:0], sda_line}; wt(Q); scl_m = 0; wt(Q);
    end
    put_bit(!ack);
  endtask

  task automatic put_data(logic [7:0] v, output bit acked);
    cmp_en = 0;
    put_byte(v, acked);
    if (acked) begin
      model[mptr] = int'(v) & keep_bits(mptr);
      mptr = (mptr + 1) % NR;
    end
    cmp_en = 1;
  endtask

  task automatic read_n(int n, string req);
    logic [7:0] b;
    for (int k = 0; k < n; k++) begin
      get_byte(k != n - 1, b);
      chk(req, int'(b), model[mptr]);
      mptr = (mptr + 1) % NR;
    end
  endtask

  initial begin
    bit a;
    for (int i = 0; i < NR; i++) model[i] = 0;
    wt(5); rst_n = 1; wt(5);
    chk("R10 sda released", int'(sda_oe), 0);
    chk("R10 bank zero", int'(regs_o == '0), 1);
    cmp_en = 1;

    // Write pointer 2, then four data bytes
    bus_start();
    put_byte(8'hD0, a); chk("R1 write address ack", int'(a), 1);
    put_byte(8'h02, a); chk("R3 pointer ack", int'(a), 1);
    if (a) mptr = 2;
    put_data(8'h15, a); chk("R3 data ack", int'(a), 1);
    put_data(8'hAA, a);
    put_data(8'hFF, a);
    put_data(8'h9A, a); chk("R3 last data ack", int'(a), 1);
    bus_stop();
    chk("R2 released after stop", int'(sda_oe), 0);

    // Set pointer 2, repeated START, read three bytes
    bus_start();
    put_byte(8'hD0, a);
    put_byte(8'h02, a); mptr = 2;
    bus_start();
    put_byte(8'hD1, a); chk("R2 repeated start read address ack", int'(a), 1);
    read_n(3, "R4 R8 sequential read");
    wt(2);
    chk("R6 released after master nack", int'(sda_oe), 0);
    bus_stop();

    // Read from leftover pointer (5)
    bus_start();
    put_byte(8'hD1, a); chk("R5 read address ack", int'(a), 1);
    read_n(1, "R5 current pointer read");
    bus_stop();

    // Wrong address: no ack, nothing stored
    bus_start();
    put_byte(8'hA0, a); chk("R1 foreign address nack", int'(a), 0);
    put_byte(8'h00, a); chk("R1 ignored byte nack", int'(a), 0);
    put_byte(8'h77, a);
    bus_stop();

    // Out-of-range pointer
    bus_start();
    put_byte(8'hD0, a);
    put_byte(8'h10, a); chk("R7 pointer 0x10 nack", int'(a), 0);
    put_data(8'h55, a); chk("R7 following byte nack", int'(a), 0);
    chk("R7 sda released", int'(sda_oe), 0);
    bus_stop();

    // Pointer kept after refusal: read continues at 6
    bus_start();
    put_byte(8'hD1, a);
    read_n(1, "R7 pointer unchanged");
    bus_stop();

    // Wrap 15 -> 0 on write and on read
    bus_start();
    put_byte(8'hD0, a);
    put_byte(8'h0F, a); mptr = 15;
    put_data(8'hFF, a);
    put_data(8'hF1, a); chk("R9 write wrap ack", int'(a), 1);
    bus_stop();
    chk("R9 index 0 written", int'(regs_o[7:0]), 'h71);
    chk("R8 index 15 masked", int'(regs_o[127:120]), 'h83);
    bus_start();
    put_byte(8'hD0, a);
    put_byte(8'h0F, a); mptr = 15;
    bus_start();
    put_byte(8'hD1, a);
    read_n(2, "R9 read wrap");
    bus_stop();

    tests++;  // continuous bank comparison, R3 R8
    done = 1;
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 150000) begin @(posedge clk); cyc++; end
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
    end
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule